// File: doc/BRIEF.md
# Infrared link interrupt status, mask and clear unit

This block gathers the single-cycle event pulses raised by the transmitter and receiver of an infrared serial link controller and reduces them to one interrupt line. It keeps two status banks, one for the slow serial mode and one shared by the two fast modes. Each bank has a sticky status register, a mask register and a write-one-to-clear register, all 16 bits wide. A mode register holds the transfer mode and a set of group masks. The mode selects which bank receives events and which bank may drive the interrupt. The group masks can block a whole bank at once.

Software reaches every register through a simple word-addressed read/write port with a registered read result. The usual handler flow is: read the status of the active bank, write the same value back to its clear register, then serve each event. Status bits are set whether or not they are masked, so a driver can also poll without taking interrupts.

Top module: `ir_irq_ctrl`

## Requirements
- R1: After reset every status bit is 0, both bank masks read 0x8B80 (all event bits masked), the mode field is 00 and the three group-mask bits are 1. The interrupt output is 0.
- R2: Event input bits 0..4 map to status bits 7 (transmit end), 8 (framing error in slow mode, CRC error in fast modes), 9 (receive timeout in slow mode, abort in fast modes), 11 (transfer-area overflow) and 15 (receive end). An event sets its bit in the slow bank when the mode field is 00 and in the fast bank when it is 10 or 11. With mode 01 events change no bank.
- R3: A status bit is set by its event even while its mask bit is 1, and it stays set until it is cleared.
- R4: Writing a 1 to a bit of a bank's clear register (slow address 3, fast address 6) clears that status bit. A 0 bit leaves it unchanged. Writes to the status addresses (1 and 4) have no effect.
- R5: When an event and a clear write hit the same status bit in the same cycle, the bit ends set.
- R6: Only bits 15, 11, 9, 8 and 7 of a mask register (slow address 2, fast address 5) can be written. All other status and mask bits read 0. A mask bit of 1 blocks its status bit from the interrupt.
- R7: One cycle after the state changes, the interrupt output is 1 exactly when the selected bank holds a status bit whose mask bit is 0 and that bank's group mask is 0. Mode register bit 0 is the slow bank's group mask and bit 4 is the fast bank's. With mode 01 the output is 0.
- R8: The mode register at address 0 holds the mode field in bits 15:14 and group masks in bits 8, 4 and 0, and reads back exactly those bits. Bit 8 (receive FIFO group) is stored and read back but has no effect on the interrupt.
- R9: A read returns its data on rdata one cycle after rd_en, taken from the state before any write in the same cycle. The clear addresses and address 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 5 | Event pulses: bit 0 tx end, 1 bit-8 error, 2 bit-9 event, 3 overflow, 4 rx end |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is the collision in which an event pulse and a clear write land on the same status bit in the same cycle. Other hard cases are an event that arrives while the mode field is 01, and an event that arrives in the same cycle a write changes the mode, so that it must still follow the old mode. Directed steps set up each of these on purpose. Long random runs then mix events, writes to every address and mode changes at high density. The bench compares every cycle of the interrupt and every read against a reference model.

// File: rtl/ir_irq_pkg.sv
package ir_irq_pkg;
  localparam int DW     = 16;
  localparam int EVW    = 5;
  localparam int AW     = 3;
  localparam int NBANK  = 2;
  localparam int REGS_PER_BANK = 3;

  typedef enum logic [1:0] {
    MD_SLOW = 2'b00,
    MD_NONE = 2'b01,
    MD_FAST = 2'b10,
    MD_MED  = 2'b11
  } xfer_mode_e;

  localparam int EV_POS [EVW] = '{7, 8, 9, 11, 15};
  localparam int GM_POS [NBANK] = '{0, 4};
  localparam int GM_FIFO_POS = 8;
  localparam int MODE_LSB = 14;

  localparam logic [AW-1:0] A_MODE = 3'd0;

  function automatic logic [DW-1:0] ev_bits_mask();
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < EVW; i++) r[EV_POS[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic [DW-1:0] ev_expand(logic [EVW-1:0] ev);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < EVW; i++) r[EV_POS[i]] = ev[i];
    return r;
  endfunction

  function automatic logic [AW-1:0] bank_addr(int b, int k);
    return AW'(1 + REGS_PER_BANK * b + k);
  endfunction
endpackage

// File: rtl/ir_irq_bank.sv
module ir_irq_bank
  import ir_irq_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wd,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  localparam logic [W-1:0] VALID = W'(ev_bits_mask());

  logic [W-1:0] stat_q, mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= VALID;
    end else begin
      stat_q <= ((stat_q & ~clr_i) | set_i) & VALID;
      if (mask_we) mask_q <= mask_wd & VALID;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & ~mask_q);
endmodule

// File: rtl/ir_irq_regif.sv
module ir_irq_regif
  import ir_irq_pkg::*;
#(
  parameter int W  = DW,
  parameter int A  = AW,
  parameter int NB = NBANK
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [A-1:0]        addr,
  input  logic [W-1:0]        wdata,
  input  logic [NB-1:0][W-1:0] stat_i,
  input  logic [NB-1:0][W-1:0] mask_i,
  output logic [NB-1:0][W-1:0] clr_o,
  output logic [NB-1:0]       mask_we_o,
  output logic [1:0]          mode_o,
  output logic [NB-1:0]       gm_o,
  output logic                gm_fifo_o,
  output logic [W-1:0]        rdata_o
);
  logic [1:0]    mode_q;
  logic [NB-1:0] gm_q;
  logic          gm_fifo_q;
  logic [W-1:0]  rd_q;
  logic [W-1:0]  rd_mux;
  logic [W-1:0]  mode_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MD_SLOW;
      gm_q      <= '1;
      gm_fifo_q <= 1'b1;
    end else if (wr_en && addr == A_MODE) begin
      mode_q    <= wdata[MODE_LSB +: 2];
      gm_fifo_q <= wdata[GM_FIFO_POS];
      for (int b = 0; b < NB; b++) gm_q[b] <= wdata[GM_POS[b]];
    end
  end

  genvar gb;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_dec
      assign clr_o[gb]     = (wr_en && addr == bank_addr(gb, 2)) ? wdata : '0;
      assign mask_we_o[gb] = wr_en && addr == bank_addr(gb, 1);
    end
  endgenerate

  always_comb begin
    mode_rd = '0;
    mode_rd[MODE_LSB +: 2] = mode_q;
    mode_rd[GM_FIFO_POS]   = gm_fifo_q;
    for (int b = 0; b < NB; b++) mode_rd[GM_POS[b]] = gm_q[b];
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_MODE) rd_mux = mode_rd;
    for (int b = 0; b < NB; b++) begin
      if (addr == bank_addr(b, 0)) rd_mux = stat_i[b];
      if (addr == bank_addr(b, 1)) rd_mux = mask_i[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign mode_o    = mode_q;
  assign gm_o      = gm_q;
  assign gm_fifo_o = gm_fifo_q;
  assign rdata_o   = rd_q;
endmodule

// File: rtl/ir_irq_merge.sv
module ir_irq_merge
  import ir_irq_pkg::*;
#(
  parameter int NB = NBANK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] pend_i,
  input  logic [NB-1:0] sel_i,
  input  logic [NB-1:0] gm_i,
  output logic          irq_o
);
  logic irq_q;
  logic any;

  always_comb begin
    any = 1'b0;
    for (int b = 0; b < NB; b++) any = any | (pend_i[b] & sel_i[b] & ~gm_i[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ir_irq_ctrl.sv
module ir_irq_ctrl
  import ir_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [EVW-1:0] ev_pulse,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq_o
);
  logic [NBANK-1:0][DW-1:0] stat_w, mask_w, clr_w;
  logic [NBANK-1:0]         mask_we_w, pend_w, sel_w, gm_w;
  logic [1:0]               mode_w;
  logic                     gm_fifo_w;
  logic [DW-1:0]            ev_vec;

  assign ev_vec   = ev_expand(ev_pulse);
  assign sel_w[0] = (mode_w == MD_SLOW);
  assign sel_w[1] = mode_w[1];

  genvar gb;
  generate
    for (gb = 0; gb < NBANK; gb++) begin : g_bank
      ir_irq_bank #(.W(DW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_i   (sel_w[gb] ? ev_vec : '0),
        .clr_i   (clr_w[gb]),
        .mask_we (mask_we_w[gb]),
        .mask_wd (wdata),
        .stat_o  (stat_w[gb]),
        .mask_o  (mask_w[gb]),
        .pend_o  (pend_w[gb])
      );
    end
  endgenerate

  ir_irq_regif #(.W(DW), .A(AW), .NB(NBANK)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .stat_i    (stat_w),
    .mask_i    (mask_w),
    .clr_o     (clr_w),
    .mask_we_o (mask_we_w),
    .mode_o    (mode_w),
    .gm_o      (gm_w),
    .gm_fifo_o (gm_fifo_w),
    .rdata_o   (rdata)
  );

  ir_irq_merge #(.NB(NBANK)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend_w),
    .sel_i  (sel_w),
    .gm_i   (gm_w),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/ir_irq_ctrl_chk.sv
module ir_irq_ctrl_chk
  import ir_irq_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic [EVW-1:0]          ev_pulse,
  input logic                    wr_en,
  input logic [AW-1:0]           addr,
  input logic [DW-1:0]           wdata,
  input logic                    irq_o,
  input logic [1:0]              mode,
  input logic [NBANK-1:0]        gm,
  input logic [NBANK-1:0][DW-1:0] stat,
  input logic [NBANK-1:0][DW-1:0] mask
);
  logic live;
  assign live = ((mode == MD_SLOW) && (|(stat[0] & ~mask[0])) && !gm[0]) ||
                (mode[1] && (|(stat[1] & ~mask[1])) && !gm[1]);

  // R1
  a_r1_irq_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !irq_o);

  // R3: masked or not, the event lands
  a_r3_slow_sets: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_SLOW && ev_pulse[4]) |=> stat[0][15]);
  a_r3_fast_sets: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && ev_pulse[0]) |=> stat[1][7]);

  // R5
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_SLOW && ev_pulse[2] && wr_en && addr == bank_addr(0, 2) && wdata[9])
      |=> stat[0][9]);

  // R2: mode 01 leaves both banks alone
  a_r2_none_mode_holds: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_NONE && !wr_en) |=> $stable(stat));

  // R7
  a_r7_irq_has_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(live));

  // R4: a bit drops only through its clear register
  genvar gb, gi;
  generate
    for (gb = 0; gb < NBANK; gb++) begin : g_b
      for (gi = 0; gi < EVW; gi++) begin : g_i
        a_r4_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
          $fell(stat[gb][EV_POS[gi]]) |->
            $past(wr_en && addr == bank_addr(gb, 2) && wdata[EV_POS[gi]]));
      end
    end
  endgenerate
endmodule

bind ir_irq_ctrl ir_irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_pulse (ev_pulse),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .irq_o    (irq_o),
  .mode     (mode_w),
  .gm       (gm_w),
  .stat     (stat_w),
  .mask     (mask_w)
);

// File: tb/ir_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ir_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ev_pulse = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [15:0] VALID = 16'h8B80;

  logic [15:0] m_stat [2];
  logic [15:0] m_mask [2];
  logic [1:0]  m_mode;
  logic [1:0]  m_gm;
  logic        m_gfifo;

  always #2.5 clk = ~clk;

  ir_irq_ctrl u_ir_irq_ctrl (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  function automatic logic [15:0] f_expand(logic [4:0] e);
    return {e[4], 3'b0, e[3], 1'b0, e[2], e[1], e[0], 7'b0};
  endfunction

  function automatic logic f_pend();
    return ((m_mode == 2'b00) && (|(m_stat[0] & ~m_mask[0])) && !m_gm[0]) ||
           (m_mode[1] && (|(m_stat[1] & ~m_mask[1])) && !m_gm[1]);
  endfunction

  function automatic logic [15:0] f_read(logic [2:0] a);
    case (a)
      3'd0: return {m_mode, 5'b0, m_gfifo, 3'b0, m_gm[1], 3'b0, m_gm[0]};
      3'd1: return m_stat[0];
      3'd2: return m_mask[0];
      3'd4: return m_stat[1];
      3'd5: return m_mask[1];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    m_stat[0] = '0; m_stat[1] = '0;
    m_mask[0] = VALID; m_mask[1] = VALID;
    m_mode = 2'b00; m_gm = 2'b11; m_gfifo = 1'b1;
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [4:0] e, logic we, logic re, logic [2:0] a,
                     logic [15:0] d, string tag);
    logic        exp_irq;
    logic [15:0] exp_rd;
    logic [15:0] set;
    @(negedge clk);
    ev_pulse = e; wr_en = we; rd_en = re; addr = a; wdata = d;
    @(posedge clk); #1;
    exp_irq = f_pend();
    exp_rd  = f_read(a);
    set = f_expand(e);
    for (int b = 0; b < 2; b++) begin
      logic sel;
      sel = (b == 0) ? (m_mode == 2'b00) : m_mode[1];
      if (we && a == 3'(3 + 3*b)) m_stat[b] = m_stat[b] & ~d;
      if (sel) m_stat[b] = m_stat[b] | set;
      if (we && a == 3'(2 + 3*b)) m_mask[b] = d & VALID;
    end
    if (we && a == 3'd0) begin
      m_mode = d[15:14]; m_gm = {d[4], d[0]}; m_gfifo = d[8];
    end
    chk("R7 irq", {15'b0, irq_o}, {15'b0, exp_irq});
    if (re) chk(tag, rdata, exp_rd);
    ev_pulse = '0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, string tag);
    cyc(5'b0, 1'b0, 1'b1, a, 16'h0, tag);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    cyc(5'b0, 1'b1, 1'b0, a, d, "wr");
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset values, R9 zeros at clear and spare addresses
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset read");
    chk("R1 irq after reset", {15'b0, irq_o}, 16'h0);
    rd(3'd3, "R9 clear reads zero");
    rd(3'd7, "R9 spare reads zero");

    // R3 masked event still sets, irq stays low
    cyc(5'b10001, 1'b0, 1'b0, 3'd0, 16'h0, "R3");
    rd(3'd1, "R3 masked status set");
    chk("R3 irq blocked by mask", {15'b0, irq_o}, 16'h0);

    // R7 open slow group and mask
    wr(3'd0, 16'h0110);
    wr(3'd2, 16'h0000);
    cyc(5'b0, 1'b0, 1'b0, 3'd0, 16'h0, "idle");
    chk("R7 irq raised", {15'b0, irq_o}, 16'h1);
    rd(3'd0, "R8 mode readback");

    // R4 zero clear, status write ignored, real clear
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0000);
    rd(3'd1, "R4 no-effect writes");
    wr(3'd3, 16'h0080);
    rd(3'd1, "R4 clear one bit");

    // R5 collision, then R9 read-before-write ordering
    cyc(5'b10000, 1'b1, 1'b0, 3'd3, 16'h8000, "R5");
    rd(3'd1, "R5 set wins");
    cyc(5'b0, 1'b1, 1'b1, 3'd3, 16'hFFFF, "R9 read sees old state");
    rd(3'd1, "R4 all cleared");

    // R6 mask writability
    wr(3'd5, 16'hFFFF);
    rd(3'd5, "R6 mask valid bits only");

    // R2 mode 01 drops events; mode change uses old mode in same cycle
    wr(3'd0, 16'h4000);
    cyc(5'b11111, 1'b0, 1'b0, 3'd0, 16'h0, "R2");
    rd(3'd1, "R2 none mode slow");
    rd(3'd4, "R2 none mode fast");
    cyc(5'b00100, 1'b1, 1'b0, 3'd0, 16'h8000, "R2");
    rd(3'd4, "R2 old mode on switch");
    cyc(5'b00010, 1'b0, 1'b0, 3'd0, 16'h0, "R2");
    rd(3'd4, "R2 fast bank set");
    rd(3'd1, "R2 slow bank untouched");

    // R8 fifo group bit has no effect; R7 fast group mask
    wr(3'd5, 16'h0000);
    wr(3'd0, 16'hC100);
    cyc(5'b0, 1'b0, 1'b0, 3'd0, 16'h0, "idle");
    chk("R8 fifo group ignored", {15'b0, irq_o}, 16'h1);
    wr(3'd0, 16'hC010);
    cyc(5'b0, 1'b0, 1'b0, 3'd0, 16'h0, "idle");
    chk("R7 fast group blocks", {15'b0, irq_o}, 16'h0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [4:0]  e;
      logic        we, re;
      logic [2:0]  a;
      logic [15:0] d;
      e  = 5'($urandom) & 5'($urandom) & 5'($urandom);
      we = ($urandom % 3) == 0;
      re = ($urandom % 2) == 0;
      a  = 3'($urandom);
      d  = 16'($urandom);
      if (we && a == 3'd0 && ($urandom % 2) == 0) d = d & 16'hFEEE;
      cyc(e, we, re, a, d, "R2 R4 R6 random read");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule